// File: doc/BRIEF.md
# Fractional-Ratio PWM Time Base

This block is the shared time base for a group of PWM channels. One of two tick enables is selected as the source. A fractional clock divider turns the selected ticks into count steps, at a ratio held as a fixed-point value with 8 fraction bits. Each count step advances an up-counter. The counter wraps at a programmable power of two. On each wrap the block drives a one-cycle overflow pulse to the channel comparators and sets a sticky raw interrupt flag. The current count is always visible on an output.

Software can pause the counter or clear it synchronously. A clear also empties the divider's remainder. With the default `STAGED` build, new divider and range settings are not used straight away. They are held back until an update request is made. The block then switches to them at the next counter wrap, so a PWM period never runs with a mix of old and new settings. Setting `STAGED` to 0 gives a variant in which the configuration inputs act at once.

Top module: `ptb_pwm_timebase`

## Requirements
- R1: `src_sel` = 1 selects `bus_tick_en` as the tick source and `src_sel` = 0 selects `ref_tick_en`. The unselected enable has no effect on the count.
- R2: After a clear, n selected ticks with divider value D (unsigned, 8 fraction bits, D >= 256) produce exactly floor(n*256/D) count steps. A tick in cycle k is reflected in `cnt_value` after the second rising edge that follows it. The count advances by at most one per cycle.
- R3: A divider value below 256 (a ratio below 1.0) behaves as 256, giving one count step per tick.
- R4: With range exponent N, the counter counts 0 .. 2^N-1 and then wraps to 0. `ovf_pulse` is high for exactly the cycle in which the wrapped value 0 first shows.
- R5: With N = 0, every count step is an overflow and `cnt_value` stays 0.
- R6: `irq_raw` is set by every overflow. It stays set until a cycle with `irq_clr` high (write-1-to-clear). A new overflow in that same cycle wins over the clear.
- R7: While `cfg_pause` is high, `cnt_value` does not change.
- R8: `cfg_clear` makes `cnt_value` 0 on the next edge and empties the divider remainder. It takes priority over pause and count steps, and it produces no overflow.
- R9 (staged build): changes on `cfg_div` and `cfg_exp` have no effect until an update request is made.
- R10 (staged build): a cycle with `upd_req` high sets `upd_pending`. The values present on `cfg_div`/`cfg_exp` are taken into use at the next counter wrap, and `upd_pending` returns to 0 on that same edge.
- R11 (staged build): a clear that arrives while `upd_pending` is set applies the pending values at once and clears `upd_pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick_en | input | 1 | Fast tick enable (source 1) |
| ref_tick_en | input | 1 | Reference tick enable (source 0) |
| src_sel | input | 1 | Tick source select |
| cfg_div | input | DIV_W (18) | Divider ratio, low FRAC_W (8) bits fractional |
| cfg_exp | input | EXP_W (5) | Range exponent N; values above CNT_W act as CNT_W |
| cfg_pause | input | 1 | Hold the counter |
| cfg_clear | input | 1 | Synchronous counter and divider clear |
| upd_req | input | 1 | Request to adopt the configuration at the next wrap |
| irq_clr | input | 1 | Write-1-to-clear for `irq_raw` |
| cnt_value | output | CNT_W (20) | Current count |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| irq_raw | output | 1 | Sticky raw overflow flag |
| upd_pending | output | 1 | An update request is waiting for a wrap |

## Verification
The hardest case to reach is a deferred update that lands on a wrap. The stimulus has to run the counter partway through a period under one range and change the configuration inputs without a request, to show they are ignored. It then raises the request mid-period and steps exactly to the wrap. After that it measures the length of the following period to prove the new range took hold on that edge and not earlier. The fractional ratios are checked against the closed form floor(n*256/D), with the ratio chosen so that the steps come out uneven.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   localparam int PTB_CNT_W  = 20;
   localparam int PTB_DIV_W  = 18;
   localparam int PTB_FRAC_W = 8;
   localparam int PTB_EXP_W  = 5;

   typedef enum logic {
      SRC_REF = 1'b0,
      SRC_BUS = 1'b1
   } ptb_src_e;
endpackage

// File: rtl/ptb_frac_div.sv
module ptb_frac_div #(
   parameter int DIV_W  = 18,
   parameter int FRAC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [DIV_W-1:0] div_q,
   output logic             step
);
   localparam int          ACC_W = DIV_W + 1;
   localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] div_eff;
   logic [ACC_W-1:0] sum;
   logic             reach;

   always_comb begin
      div_eff = {1'b0, div_q};
      if (div_eff < UNIT) div_eff = UNIT;
      sum   = acc + UNIT;
      reach = (sum >= div_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         step <= 1'b0;
      end else if (clr) begin
         acc  <= '0;
         step <= 1'b0;
      end else if (tick) begin
         acc  <= reach ? (sum - div_eff) : sum;
         step <= reach;
      end else begin
         step <= 1'b0;
      end
   end
endmodule

// File: rtl/ptb_wrap_counter.sv
module ptb_wrap_counter #(
   parameter int CNT_W = 20,
   parameter int EXP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             pause,
   input  logic             clr,
   input  logic [EXP_W-1:0] range_exp,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_evt,
   output logic             ovf_q
);
   localparam int TOP_W = CNT_W + 1;

   logic [EXP_W-1:0] exp_c;
   logic [TOP_W-1:0] top;
   logic             hit;
   logic             adv;

   always_comb begin
      exp_c    = (range_exp > EXP_W'(CNT_W)) ? EXP_W'(CNT_W) : range_exp;
      top      = (TOP_W'(1) << exp_c) - TOP_W'(1);
      hit      = ({1'b0, cnt} >= top);
      adv      = step & ~pause & ~clr;
      wrap_evt = adv & hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ovf_q <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         ovf_q <= 1'b0;
      end else if (adv) begin
         cnt   <= hit ? '0 : cnt + CNT_W'(1);
         ovf_q <= hit;
      end else begin
         ovf_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ptb_cfg_stage.sv
module ptb_cfg_stage #(
   parameter int              DIV_W   = 18,
   parameter int              EXP_W   = 5,
   parameter bit              STAGED  = 1'b1,
   parameter logic [DIV_W-1:0] RST_DIV = DIV_W'(256),
   parameter logic [EXP_W-1:0] RST_EXP = EXP_W'(4)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic             upd_req,
   input  logic             wrap_evt,
   input  logic             clr,
   output logic [DIV_W-1:0] act_div,
   output logic [EXP_W-1:0] act_exp,
   output logic             pending
);
   generate
      if (STAGED) begin : g_staged
         logic take;
         assign take = pending & (wrap_evt | clr);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_div <= RST_DIV;
               act_exp <= RST_EXP;
               pending <= 1'b0;
            end else begin
               if (take) begin
                  act_div <= cfg_div;
                  act_exp <= cfg_exp;
               end
               if (take)         pending <= 1'b0;
               else if (upd_req) pending <= 1'b1;
            end
         end
      end else begin : g_direct
         logic unused_stage;
         assign unused_stage = ^{clk, rst_n, upd_req, wrap_evt, clr};
         assign act_div = cfg_div;
         assign act_exp = cfg_exp;
         assign pending = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ptb_pwm_timebase.sv
module ptb_pwm_timebase
   import ptb_pkg::*;
#(
   parameter int CNT_W  = PTB_CNT_W,
   parameter int DIV_W  = PTB_DIV_W,
   parameter int FRAC_W = PTB_FRAC_W,
   parameter int EXP_W  = PTB_EXP_W,
   parameter bit STAGED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_tick_en,
   input  logic             ref_tick_en,
   input  logic             src_sel,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [EXP_W-1:0] cfg_exp,
   input  logic             cfg_pause,
   input  logic             cfg_clear,
   input  logic             upd_req,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] cnt_value,
   output logic             ovf_pulse,
   output logic             irq_raw,
   output logic             upd_pending
);
   if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt
      $error("ptb_pwm_timebase: CNT_W out of range");
   end
   if (FRAC_W < 1 || FRAC_W >= DIV_W) begin : g_bad_frac
      $error("ptb_pwm_timebase: FRAC_W must be below DIV_W");
   end
   if ((1 << EXP_W) <= CNT_W) begin : g_bad_exp
      $error("ptb_pwm_timebase: EXP_W too narrow to reach CNT_W");
   end

   logic             tick_sel;
   logic             step;
   logic             wrap_evt;
   logic [DIV_W-1:0] act_div;
   logic [EXP_W-1:0] act_exp;

   always_comb begin
      tick_sel = (ptb_src_e'(src_sel) == SRC_BUS) ? bus_tick_en : ref_tick_en;
   end

   ptb_cfg_stage #(
      .DIV_W  (DIV_W),
      .EXP_W  (EXP_W),
      .STAGED (STAGED),
      .RST_DIV(DIV_W'(1) << FRAC_W),
      .RST_EXP(EXP_W'(4))
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_div (cfg_div),
      .cfg_exp (cfg_exp),
      .upd_req (upd_req),
      .wrap_evt(wrap_evt),
      .clr     (cfg_clear),
      .act_div (act_div),
      .act_exp (act_exp),
      .pending (upd_pending)
   );

   ptb_frac_div #(
      .DIV_W (DIV_W),
      .FRAC_W(FRAC_W)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_sel),
      .clr  (cfg_clear),
      .div_q(act_div),
      .step (step)
   );

   ptb_wrap_counter #(
      .CNT_W(CNT_W),
      .EXP_W(EXP_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .pause    (cfg_pause),
      .clr      (cfg_clear),
      .range_exp(act_exp),
      .cnt      (cnt_value),
      .wrap_evt (wrap_evt),
      .ovf_q    (ovf_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_raw <= 1'b0;
      else if (wrap_evt) irq_raw <= 1'b1;
      else if (irq_clr)  irq_raw <= 1'b0;
   end
endmodule

// File: rtl/ptb_pwm_timebase_chk.sv
module ptb_pwm_timebase_chk #(
   parameter int CNT_W  = 20,
   parameter bit STAGED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_pause,
   input logic             cfg_clear,
   input logic             irq_clr,
   input logic [CNT_W-1:0] cnt_value,
   input logic             ovf_pulse,
   input logic             irq_raw,
   input logic             upd_pending
);
   // R4: an overflow is flagged only with the wrapped value showing
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (cnt_value == '0));

   // R2: the count moves by single steps unless a clear or a wrap happens
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_value != $past(cnt_value)) && !$past(cfg_clear) && !ovf_pulse)
      |-> (cnt_value == $past(cnt_value) + CNT_W'(1)));

   // R6: overflow sets the flag
   a_r6_flag_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> irq_raw);

   // R6: flag holds without a clear request
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw && !irq_clr) |=> irq_raw);

   // R7: pause freezes the count
   a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pause && !cfg_clear) |=> $stable(cnt_value));

   // R8: clear zeroes the count without an overflow
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clear |=> (cnt_value == '0) && !ovf_pulse);

   // R10 / R11: a pending update only retires on a wrap or a clear
   generate
      if (STAGED) begin : g_pend
         a_r10_pending_retire: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(upd_pending) |-> (ovf_pulse || $past(cfg_clear)));
      end
   endgenerate
endmodule

bind ptb_pwm_timebase ptb_pwm_timebase_chk #(
   .CNT_W (CNT_W),
   .STAGED(STAGED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_pause  (cfg_pause),
   .cfg_clear  (cfg_clear),
   .irq_clr    (irq_clr),
   .cnt_value  (cnt_value),
   .ovf_pulse  (ovf_pulse),
   .irq_raw    (irq_raw),
   .upd_pending(upd_pending)
);

// File: tb/ptb_pwm_timebase_test.sv
module ptb_pwm_timebase_test;
   localparam int CNT_W = 20;
   localparam int DIV_W = 18;
   localparam int EXP_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_tick_en = 1'b0;
   logic             ref_tick_en = 1'b0;
   logic             src_sel = 1'b1;
   logic [DIV_W-1:0] cfg_div = DIV_W'(256);
   logic [EXP_W-1:0] cfg_exp = EXP_W'(4);
   logic             cfg_pause = 1'b0;
   logic             cfg_clear = 1'b0;
   logic             upd_req = 1'b0;
   logic             irq_clr = 1'b0;
   logic [CNT_W-1:0] cnt_value;
   logic             ovf_pulse;
   logic             irq_raw;
   logic             upd_pending;

   int n_checks = 0;
   int n_fail   = 0;
   int ovf_seen = 0;

   always #2.5 clk = ~clk;

   ptb_pwm_timebase uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_tick_en(bus_tick_en),
      .ref_tick_en(ref_tick_en),
      .src_sel    (src_sel),
      .cfg_div    (cfg_div),
      .cfg_exp    (cfg_exp),
      .cfg_pause  (cfg_pause),
      .cfg_clear  (cfg_clear),
      .upd_req    (upd_req),
      .irq_clr    (irq_clr),
      .cnt_value  (cnt_value),
      .ovf_pulse  (ovf_pulse),
      .irq_raw    (irq_raw),
      .upd_pending(upd_pending)
   );

   always @(negedge clk) if (rst_n && ovf_pulse) ovf_seen++;

   task automatic check(input string req, input string what,
                        input longint got, input longint exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks_bus(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_tick_en = 1'b1;
      end
      @(negedge clk);
      bus_tick_en = 1'b0;
      idle(3);
   endtask

   task automatic ticks_ref(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_tick_en = 1'b1;
      end
      @(negedge clk);
      ref_tick_en = 1'b0;
      idle(3);
   endtask

   // stage a configuration, request an update and apply it with a clear
   task automatic setup(input int div, input int ex);
      @(negedge clk);
      cfg_div = DIV_W'(div);
      cfg_exp = EXP_W'(ex);
      upd_req = 1'b1;
      @(negedge clk);
      upd_req   = 1'b0;
      cfg_clear = 1'b1;
      @(negedge clk);
      cfg_clear = 1'b0;
      irq_clr   = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      idle(1);
   endtask

   task automatic t_reset;
      check("reset", "cnt_value", cnt_value, 0);
      check("reset", "ovf_pulse", ovf_pulse, 0);
      check("reset", "irq_raw", irq_raw, 0);
      check("reset", "upd_pending", upd_pending, 0);
   endtask

   task automatic t_unit_ratio;
      setup(256, 8);
      check("R11", "pending after clear", upd_pending, 0);
      check("R8", "count after clear", cnt_value, 0);
      ticks_bus(10);
      check("R2", "ratio 1.0, 10 ticks", cnt_value, 10);
   endtask

   task automatic t_fractional;
      setup(384, 8);
      ticks_bus(9);
      check("R2", "ratio 1.5, 9 ticks", cnt_value, (9 * 256) / 384);
      setup(640, 8);
      ticks_bus(10);
      check("R2", "ratio 2.5, 10 ticks", cnt_value, (10 * 256) / 640);
      ticks_bus(3);
      check("R2", "ratio 2.5, 13 ticks", cnt_value, (13 * 256) / 640);
   endtask

   task automatic t_below_one;
      setup(100, 8);
      ticks_bus(5);
      check("R3", "ratio below 1.0", cnt_value, 5);
   endtask

   task automatic t_source;
      setup(256, 8);
      src_sel = 1'b1;
      ticks_ref(4);
      check("R1", "ref ignored when bus selected", cnt_value, 0);
      ticks_bus(2);
      check("R1", "bus counts when selected", cnt_value, 2);
      src_sel = 1'b0;
      ticks_bus(5);
      check("R1", "bus ignored when ref selected", cnt_value, 2);
      ticks_ref(3);
      check("R1", "ref counts when selected", cnt_value, 5);
      src_sel = 1'b1;
   endtask

   task automatic t_wrap_irq;
      int base;
      setup(256, 3);
      base = ovf_seen;
      ticks_bus(11);
      check("R4", "count after 11 steps, range 8", cnt_value, 3);
      check("R4", "overflow pulses", ovf_seen - base, 1);
      check("R6", "flag set", irq_raw, 1);
      idle(4);
      check("R6", "flag held", irq_raw, 1);
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
      check("R6", "flag cleared", irq_raw, 0);
      idle(3);
      check("R6", "flag stays clear", irq_raw, 0);
   endtask

   task automatic t_exp_zero;
      int base;
      setup(256, 0);
      base = ovf_seen;
      ticks_bus(3);
      check("R5", "count stays 0", cnt_value, 0);
      check("R5", "each step overflows", ovf_seen - base, 3);
   endtask

   task automatic t_pause_clear;
      setup(256, 8);
      ticks_bus(5);
      check("R7", "before pause", cnt_value, 5);
      cfg_pause = 1'b1;
      ticks_bus(6);
      check("R7", "paused count", cnt_value, 5);
      cfg_pause = 1'b0;
      ticks_bus(2);
      check("R7", "resumed count", cnt_value, 7);
      @(negedge clk) cfg_clear = 1'b1;
      @(negedge clk) cfg_clear = 1'b0;
      check("R8", "cleared count", cnt_value, 0);
   endtask

   task automatic t_staged;
      int base;
      setup(256, 3);
      base = ovf_seen;
      ticks_bus(8);
      check("R4", "wrap at 8", cnt_value, 0);
      cfg_exp = EXP_W'(2);
      ticks_bus(4);
      check("R9", "range unchanged without request", cnt_value, 4);
      check("R9", "no wrap without request", ovf_seen - base, 1);
      @(negedge clk) upd_req = 1'b1;
      @(negedge clk) upd_req = 1'b0;
      check("R10", "pending set", upd_pending, 1);
      ticks_bus(3);
      check("R10", "old range until wrap", cnt_value, 7);
      check("R10", "still pending", upd_pending, 1);
      ticks_bus(1);
      check("R10", "wrap with old range", cnt_value, 0);
      check("R10", "pending retired at wrap", upd_pending, 0);
      ticks_bus(4);
      check("R10", "new range period 4", cnt_value, 0);
      check("R10", "overflow count", ovf_seen - base, 3);
      ticks_bus(3);
      check("R10", "count in new range", cnt_value, 3);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_unit_ratio;
      t_fractional;
      t_below_one;
      t_source;
      t_wrap_irq;
      t_exp_zero;
      t_pause_clear;
      t_staged;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule